// File: doc/BRIEF.md
# PCI-to-DMA Window Address Translator

This block turns an inbound PCI bus address into a system DMA address. It compares the address against a set of programmable windows. Each window has three register values: a base, a size mask and a translated base. A window either maps the address directly, replacing the upper bits with the translated base, or maps it through a one-level scatter-gather page table with 8 KB pages. In the scatter-gather case the block works out where the page table entry lives and reads that entry over a 64-bit memory port. It then builds the final address from the entry it gets back.

A requester offers an address with a one-cycle request strobe. The block answers with a one-cycle done pulse, and the result stays on the result output until the next completion. The memory port has a valid/ready request channel and a valid-only response channel, so a scatter-gather lookup takes as long as memory takes. An address that no window claims comes back unchanged.

Top module: `dma_window_xlat`

## Requirements
- R1: Windows are examined from index 0 upward. The lowest-indexed window that both matches and is enabled supplies the translation, even when a higher window also matches.
- R2: A window matches when the bus address and the window base agree on every bit in positions 31:20 where the window's mask register holds 0. Address bits 63:32 and 19:0 take no part in the match.
- R3: Bit 0 of a window base register enables the window. A matching window with bit 0 clear is skipped, and the search goes on to the next window.
- R4: Bit 1 of a window base register selects scatter-gather (1) or direct (0) mapping. For a direct window, let the offset field be mask bits 31:20 together with bits 19:0 all ones. The result takes the bus address bits inside the offset field and the translated-base bits outside it.
- R5: For a scatter-gather window, the entry address is built in two parts. The first is the translated base with the bits of ((mask & 0xFFF00000) >> 10) | 0x3FF cleared. The second is the bus address bits under (mask & 0xFFF00000) | 0xFE000, shifted right by 10. The two parts are ORed. The entry address is offered on the memory request port, and the request holds with a stable address until ready is seen.
- R6: For a scatter-gather window, the result is the returned entry with bit 0 cleared, shifted left by 12, and ORed with bus address bits 12:0.
- R7: A translated result of a hit window is cut to its low 34 bits, so bits 63:34 are zero.
- R8: When no window hits, the result equals the full 64-bit bus address and no memory read is issued.
- R9: Done is high for exactly one cycle per accepted request. For a direct hit or a miss, done is high in the cycle right after the request is accepted.
- R10: A request strobe that arrives while a translation is in flight is ignored. It produces no result and no done pulse. The result output changes only in a cycle in which done is high.
- R11: After reset, done is low, the memory request valid is low and the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_base_i | input | NUM_WIN*64 | Window base registers, window k in bits [64k+63:64k]. Bit 0 enables the window, bit 1 selects scatter-gather |
| win_mask_i | input | NUM_WIN*64 | Window size masks; only bits 31:20 are used |
| win_xbase_i | input | NUM_WIN*64 | Translated base (direct) or page table base (scatter-gather) |
| req_valid_i | input | 1 | One-cycle request strobe, taken only when idle |
| req_addr_i | input | 64 | Bus address to translate |
| mem_req_valid_o | output | 1 | Page table entry read request |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_req_addr_o | output | 64 | Page table entry address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Page table entry returned by memory |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Translated DMA address, held until the next completion |

## Verification
If the controller's state is wrong, done pulses go missing or double, or a scatter-gather lookup stalls. The bench sees either within a few cycles of the request, through its done counter and timeout. If the hit selection is wrong, the wrong window's mapping appears on the result at the done pulse. It can also show up as a memory read for a window that should map directly, or as no read at all, in the same transaction. A stale captured offset or entry address shows up on the memory request address or in bits 12:0 of the result. The bench sweeps every enable and mode pattern over overlapping windows so that such faults cannot stay hidden.

// File: rtl/dxlat_pkg.sv
package dxlat_pkg;

    localparam int ADDR_W = 64;

    localparam logic [ADDR_W-1:0] CMP_FIELD = 64'h0000_0000_FFF0_0000;
    localparam logic [ADDR_W-1:0] LOW_FIELD = 64'h0000_0000_000F_FFFF;
    localparam logic [ADDR_W-1:0] IDX_FIELD = 64'h0000_0000_000F_E000;
    localparam logic [ADDR_W-1:0] ALIGN_LOW = 64'h0000_0000_0000_03FF;
    localparam int PAGE_SHIFT = 13;
    localparam int PTE_SHIFT  = 10;
    localparam int PFN_SHIFT  = 12;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } xl_state_e;

    typedef struct packed {
        logic              hit;
        logic              sg;
        logic [ADDR_W-1:0] direct_addr;
        logic [ADDR_W-1:0] pte_addr;
    } win_res_t;

    function automatic logic win_match(input logic [ADDR_W-1:0] bus,
                                       input logic [ADDR_W-1:0] base,
                                       input logic [ADDR_W-1:0] mask);
        logic [ADDR_W-1:0] cmp;
        cmp = ~mask & CMP_FIELD;
        return ((bus & cmp) == (base & cmp));
    endfunction

    function automatic logic [ADDR_W-1:0] direct_map(input logic [ADDR_W-1:0] bus,
                                                     input logic [ADDR_W-1:0] mask,
                                                     input logic [ADDR_W-1:0] xbase);
        logic [ADDR_W-1:0] off;
        off = (mask & CMP_FIELD) | LOW_FIELD;
        return (xbase & ~off) | (bus & off);
    endfunction

    function automatic logic [ADDR_W-1:0] pte_locate(input logic [ADDR_W-1:0] bus,
                                                     input logic [ADDR_W-1:0] mask,
                                                     input logic [ADDR_W-1:0] xbase);
        logic [ADDR_W-1:0] keep;
        logic [ADDR_W-1:0] idx;
        keep = ~(((mask & CMP_FIELD) >> PTE_SHIFT) | ALIGN_LOW);
        idx  = (mask & CMP_FIELD) | IDX_FIELD;
        return (xbase & keep) | ((bus & idx) >> PTE_SHIFT);
    endfunction

    function automatic logic [ADDR_W-1:0] sg_final(input logic [ADDR_W-1:0] entry,
                                                   input logic [PAGE_SHIFT-1:0] page_off);
        logic [ADDR_W-1:0] pfn;
        pfn = entry & ~{{(ADDR_W-1){1'b0}}, 1'b1};
        return (pfn << PFN_SHIFT) | {{(ADDR_W-PAGE_SHIFT){1'b0}}, page_off};
    endfunction

endpackage

// File: rtl/xlat_window.sv
module xlat_window
    import dxlat_pkg::*;
(
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] mask_i,
    input  logic [ADDR_W-1:0] xbase_i,
    input  logic [ADDR_W-1:0] bus_i,
    output win_res_t          res_o
);

    logic matched;

    always_comb begin
        matched           = win_match(bus_i, base_i, mask_i);
        res_o.hit         = matched & base_i[0];
        res_o.sg          = base_i[1];
        res_o.direct_addr = direct_map(bus_i, mask_i, xbase_i);
        res_o.pte_addr    = pte_locate(bus_i, mask_i, xbase_i);
    end

endmodule

// File: rtl/xlat_pick.sv
module xlat_pick
    import dxlat_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  win_res_t           res_i [NUM_WIN],
    output logic [NUM_WIN-1:0] sel_oh_o,
    output logic               any_hit_o,
    output win_res_t           chosen_o
);

    logic [NUM_WIN:0] blocked;

    assign blocked[0] = 1'b0;

    genvar k;
    generate
        for (k = 0; k < NUM_WIN; k++) begin : g_prio
            assign sel_oh_o[k]  = res_i[k].hit & ~blocked[k];
            assign blocked[k+1] = blocked[k] | res_i[k].hit;
        end
    endgenerate

    assign any_hit_o = blocked[NUM_WIN];

    always_comb begin
        chosen_o = '0;
        for (int j = 0; j < NUM_WIN; j++) begin
            if (sel_oh_o[j]) begin
                chosen_o = res_i[j];
            end
        end
    end

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
    import dxlat_pkg::*;
#(
    parameter int DMA_W = 34
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              any_hit_i,
    input  win_res_t          chosen_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [ADDR_W-1:0] mem_rsp_data_i,
    output logic              done_o,
    output logic [ADDR_W-1:0] result_o,
    output logic              hit_o
);

    localparam logic [ADDR_W-1:0] DMA_MASK =
        {{(ADDR_W-DMA_W){1'b0}}, {DMA_W{1'b1}}};

    xl_state_e               state_q;
    logic [ADDR_W-1:0]       result_q;
    logic [ADDR_W-1:0]       pte_q;
    logic [PAGE_SHIFT-1:0]   page_off_q;
    logic                    sent_q;
    logic                    hit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            result_q   <= '0;
            pte_q      <= '0;
            page_off_q <= '0;
            sent_q     <= 1'b0;
            hit_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid_i) begin
                        hit_q <= any_hit_i;
                        if (any_hit_i && chosen_i.sg) begin
                            pte_q      <= chosen_i.pte_addr;
                            page_off_q <= req_addr_i[PAGE_SHIFT-1:0];
                            sent_q     <= 1'b0;
                            state_q    <= ST_FETCH;
                        end else begin
                            result_q <= any_hit_i ? (chosen_i.direct_addr & DMA_MASK)
                                                  : req_addr_i;
                            state_q  <= ST_DONE;
                        end
                    end
                end
                ST_FETCH: begin
                    if (!sent_q && mem_req_ready_i) begin
                        sent_q <= 1'b1;
                    end
                    if (sent_q && mem_rsp_valid_i) begin
                        result_q <= sg_final(mem_rsp_data_i, page_off_q) & DMA_MASK;
                        state_q  <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign mem_req_valid_o = (state_q == ST_FETCH) && !sent_q;
    assign mem_req_addr_o  = pte_q;
    assign done_o          = (state_q == ST_DONE);
    assign result_o        = result_q;
    assign hit_o           = hit_q;

endmodule

// File: rtl/dma_window_xlat.sv
module dma_window_xlat
    import dxlat_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int DMA_W   = 34
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_WIN*ADDR_W-1:0] win_base_i,
    input  logic [NUM_WIN*ADDR_W-1:0] win_mask_i,
    input  logic [NUM_WIN*ADDR_W-1:0] win_xbase_i,
    input  logic                      req_valid_i,
    input  logic [ADDR_W-1:0]         req_addr_i,
    output logic                      mem_req_valid_o,
    input  logic                      mem_req_ready_i,
    output logic [ADDR_W-1:0]         mem_req_addr_o,
    input  logic                      mem_rsp_valid_i,
    input  logic [ADDR_W-1:0]         mem_rsp_data_i,
    output logic                      done_o,
    output logic [ADDR_W-1:0]         result_o
);

    win_res_t           win_res [NUM_WIN];
    win_res_t           chosen;
    logic [NUM_WIN-1:0] sel_oh;
    logic               any_hit;
    logic               hit_q;

    genvar k;
    generate
        for (k = 0; k < NUM_WIN; k++) begin : g_win
            xlat_window u_win (
                .base_i  (win_base_i [k*ADDR_W +: ADDR_W]),
                .mask_i  (win_mask_i [k*ADDR_W +: ADDR_W]),
                .xbase_i (win_xbase_i[k*ADDR_W +: ADDR_W]),
                .bus_i   (req_addr_i),
                .res_o   (win_res[k])
            );
        end
    endgenerate

    xlat_pick #(.NUM_WIN(NUM_WIN)) u_pick (
        .res_i     (win_res),
        .sel_oh_o  (sel_oh),
        .any_hit_o (any_hit),
        .chosen_o  (chosen)
    );

    xlat_ctrl #(.DMA_W(DMA_W)) u_ctrl (
        .clk             (clk),
        .rst             (rst),
        .req_valid_i     (req_valid_i),
        .req_addr_i      (req_addr_i),
        .any_hit_i       (any_hit),
        .chosen_i        (chosen),
        .mem_req_valid_o (mem_req_valid_o),
        .mem_req_ready_i (mem_req_ready_i),
        .mem_req_addr_o  (mem_req_addr_o),
        .mem_rsp_valid_i (mem_rsp_valid_i),
        .mem_rsp_data_i  (mem_rsp_data_i),
        .done_o          (done_o),
        .result_o        (result_o),
        .hit_o           (hit_q)
    );

endmodule

// File: rtl/xlat_checker.sv
module xlat_checker #(
    parameter int NUM_WIN = 4,
    parameter int DMA_W   = 34
) (
    input logic               clk,
    input logic               rst,
    input logic               done_o,
    input logic [63:0]        result_o,
    input logic               mem_req_valid_o,
    input logic               mem_req_ready_i,
    input logic [63:0]        mem_req_addr_o,
    input logic               hit_q,
    input logic [NUM_WIN-1:0] sel_oh
);

    // R9: completion is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R10: result only moves together with a done pulse
    p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(result_o) |-> done_o);

    // R5: an unaccepted entry read keeps valid and address
    p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

    // R8: no read outstanding while reporting completion
    p_no_read_at_done_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !mem_req_valid_o);

    // R7: a hit result fits in DMA_W bits
    p_hit_trunc_r7: assert property (@(posedge clk) disable iff (rst)
        (done_o && hit_q) |-> (result_o[63:DMA_W] == '0));

    // R1: at most one window is selected
    p_single_sel_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_oh));

endmodule

bind dma_window_xlat xlat_checker #(.NUM_WIN(NUM_WIN), .DMA_W(DMA_W)) u_xlat_checker (
    .clk             (clk),
    .rst             (rst),
    .done_o          (done_o),
    .result_o        (result_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o  (mem_req_addr_o),
    .hit_q           (hit_q),
    .sel_oh          (sel_oh)
);

// File: tb/test_dma_window_xlat.sv
`timescale 1ns/1ps
module test_dma_window_xlat;

    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [63:0]   wb [NW];
    logic [63:0]   wm [NW];
    logic [63:0]   tb [NW];
    logic [NW*64-1:0] win_base, win_mask, win_xbase;
    logic          req_valid = 1'b0;
    logic [63:0]   req_addr  = '0;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic [63:0]   mem_req_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [63:0]   mem_rsp_data  = '0;
    logic          done;
    logic [63:0]   result;

    int checks = 0;
    int fails  = 0;
    int reads_seen = 0;
    int done_seen  = 0;
    int lat_cnt    = 0;
    logic [63:0] last_pte = '0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign win_base  = {wb[3], wb[2], wb[1], wb[0]};
    assign win_mask  = {wm[3], wm[2], wm[1], wm[0]};
    assign win_xbase = {tb[3], tb[2], tb[1], tb[0]};

    dma_window_xlat i_dma_window_xlat (
        .clk             (clk),
        .rst             (rst),
        .win_base_i      (win_base),
        .win_mask_i      (win_mask),
        .win_xbase_i     (win_xbase),
        .req_valid_i     (req_valid),
        .req_addr_i      (req_addr),
        .mem_req_valid_o (mem_req_valid),
        .mem_req_ready_i (mem_req_ready),
        .mem_req_addr_o  (mem_req_addr),
        .mem_rsp_valid_i (mem_rsp_valid),
        .mem_rsp_data_i  (mem_rsp_data),
        .done_o          (done),
        .result_o        (result)
    );

    function automatic logic [63:0] entry_of(input logic [63:0] a);
        return (a * 64'h0000_0000_0009_E377) ^ 64'h0000_0000_0055_AA01;
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // memory model: accepts the entry read after a short, varying delay
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && mem_req_valid) begin
                last_pte = mem_req_addr;
                reads_seen++;
                repeat (lat_cnt % 3) @(negedge clk);
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat ((lat_cnt / 3) % 3) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = entry_of(last_pte);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = '0;
                lat_cnt++;
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (done) done_seen++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // expected translation from the requirements
    task automatic model(input logic [63:0] bus, output bit hit, output bit sg,
                         output logic [63:0] pte, output logic [63:0] direct);
        hit = 0; sg = 0; pte = '0; direct = bus;                 // R8
        for (int i = 0; i < NW; i++) begin
            logic [63:0] cmp, off, keep, idx;
            if (hit) continue;                                   // R1
            cmp = ~wm[i] & 64'hFFF0_0000;                        // R2
            if (((bus ^ wb[i]) & cmp) != 0) continue;
            if (!wb[i][0]) continue;                             // R3
            hit = 1;
            sg  = wb[i][1];
            off    = (wm[i] & 64'hFFF0_0000) | 64'hF_FFFF;      // R4
            direct = ((tb[i] & ~off) | (bus & off)) & 64'h3_FFFF_FFFF; // R7
            keep = ~(((wm[i] & 64'hFFF0_0000) >> 10) | 64'h3FF); // R5
            idx  = (wm[i] & 64'hFFF0_0000) | 64'hF_E000;
            pte  = (tb[i] & keep) | ((bus & idx) >> 10);
        end
    endtask

    task automatic translate(input logic [63:0] bus, input bit inject);
        bit hit, sg;
        logic [63:0] pte, direct, exp;
        int rd0, dn0, wait_cyc;
        model(bus, hit, sg, pte, direct);
        rd0 = reads_seen;
        dn0 = done_seen;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = bus;
        @(negedge clk);
        req_valid = 1'b0;
        wait_cyc = 1;
        if (inject && !done) begin
            // R10: strobe a different address mid-flight
            req_valid = 1'b1;
            req_addr  = 64'h0000_0001_7000_0000;
            @(negedge clk);
            req_valid = 1'b0;
            req_addr  = bus;
            wait_cyc++;
        end
        while (!done && wait_cyc < 40) begin
            @(negedge clk);
            wait_cyc++;
        end
        if (hit && sg) begin
            exp = (((entry_of(pte) & ~64'h1) << 12) | (bus & 64'h1FFF)) & 64'h3_FFFF_FFFF;
            check(reads_seen == rd0 + 1, "R5 one entry read", reads_seen - rd0, 1);
            check(last_pte == pte, "R5 entry address", last_pte, pte);
            check(done && result == exp, "R6 scatter-gather result", result, exp);
        end else begin
            exp = direct;
            check(reads_seen == rd0, "R8 no read for direct/miss", reads_seen - rd0, 0);
            check(done && result == exp, hit ? "R4 direct result" : "R8 miss passthrough",
                  result, exp);
            if (!inject) check(wait_cyc == 1, "R9 done latency", wait_cyc, 1);
        end
        if (hit) check(result[63:34] == 0, "R7 truncation", result, exp);
        @(negedge clk);
        check(!done && done_seen == dn0 + 1, "R9 single done", done_seen - dn0, 1);
        if (inject) begin
            repeat (4) @(negedge clk);
            check(done_seen == dn0 + 1 && result == exp, "R10 ignored request",
                  result, exp);
        end
    endtask

    logic [63:0] addrs [10];

    initial begin
        wm[0] = 64'h0FF0_0000; tb[0] = 64'h0000_0003_A5A0_0000;
        wm[1] = 64'h0000_0000; tb[1] = 64'h0000_0001_0BC0_0000;
        wm[2] = 64'h0030_0000; tb[2] = 64'h0000_0000_7654_3000;
        wm[3] = 64'h3FF0_0000; tb[3] = 64'h0000_0002_F000_0000;
        wb[0] = 64'h4000_0000; wb[1] = 64'h4000_0000;
        wb[2] = 64'h8000_0000; wb[3] = 64'hC000_0000;
        addrs[0] = 64'h0000_0000_4000_1234;
        addrs[1] = 64'h0000_0000_4050_0008;
        addrs[2] = 64'h0000_0000_8012_3456;
        addrs[3] = 64'h0000_0000_C345_6789;
        addrs[4] = 64'h0000_0001_0000_0010;
        addrs[5] = 64'h0000_0000_7FFF_FFF8;
        addrs[6] = 64'h0000_0000_803F_FFFF;
        addrs[7] = 64'h0000_0000_8040_0000;
        addrs[8] = 64'hFFFF_FFFF_FFFF_FFFF;
        addrs[9] = 64'hABCD_0000_400F_E001;

        repeat (3) @(negedge clk);
        // R11: reset state
        check(!done, "R11 done low", done, 0);
        check(!mem_req_valid, "R11 read idle", mem_req_valid, 0);
        check(result == 0, "R11 result zero", result, 0);
        rst = 1'b0;
        @(negedge clk);

        for (int en = 0; en < 16; en++) begin
            for (int sgp = 0; sgp < 16; sgp++) begin
                for (int w = 0; w < NW; w++) begin
                    wb[w][0] = en[w];
                    wb[w][1] = sgp[w];
                end
                for (int a = 0; a < 10; a++) begin
                    translate(addrs[a], 1'b0);
                end
            end
        end

        // R10: stray strobes during a scatter-gather fetch
        for (int w = 0; w < NW; w++) begin
            wb[w][0] = 1'b1;
            wb[w][1] = 1'b1;
        end
        translate(addrs[2], 1'b1);
        translate(addrs[3], 1'b1);
        translate(addrs[0], 1'b1);

        finish_run();
    end

endmodule